// File: doc/BRIEF.md
# USB IN Data Packet Transmitter

This block answers a host IN token aimed at one transmit endpoint. When the token strobe arrives, it sends a complete full-speed packet on a differential pair. The packet is a synchronisation pattern, a DATA0 or DATA1 packet identifier, the payload read byte by byte from the endpoint FIFO, a 16-bit CRC and an end-of-packet signal. Software or a DMA engine fills the FIFO beforehand. The payload goes from the FIFO through the CRC, the bit stuffer and the NRZI encoder in a single pass, so the block holds no packet buffer. A payload of zero bytes produces a valid zero-length data packet.

When the endpoint is marked stalled at the time of the token, the block sends a STALL handshake in place of the data packet and leaves the FIFO untouched. Each bit time lasts a fixed number of clock cycles, set by a parameter. The line drivers are enabled only while a packet is on the wire.

Top module: `usb_in_xmit`

## Requirements
- R1: A packet starts only on an `in_tok` pulse seen while the block is idle. The line is first driven on the CLKS_PER_BIT-th rising clock edge after the edge that samples the token. Token pulses that arrive while a packet is in progress have no effect.
- R2: Every packet opens with the byte 0x80 sent LSB-first. After NRZI encoding from the idle J state, the eight bit times read K J K J K J K K.
- R3: The packet identifier byte holds the 4-bit PID in bits 3:0 and its ones-complement in bits 7:4, sent LSB-first. The PID is DATA0 = 0011 when `pid_odd` is 0 and DATA1 = 1011 when `pid_odd` is 1, so the bytes are 0xC3 and 0x4B.
- R4: Payload bytes leave in FIFO order, each LSB-first. The FIFO is show-ahead: `fifo_data` shows the head byte. `fifo_rd` pulses for one cycle when that byte is taken, and exactly one pulse occurs per payload byte.
- R5: The CRC uses x^16+x^15+x^2+1 over the payload bits in transmit order. It is computed in reflected form: preset 0xFFFF, and per bit the register shifts right and is XORed with 0xA001 when the old bit 0 differs from the data bit. The inverted register goes out LSB-first. A zero-length packet therefore carries the CRC 0x0000.
- R6: A zero bit is inserted after every six consecutive one bits. The run count spans the sync, PID, payload and CRC fields, and a run that ends at the last CRC bit is stuffed before the EOP. The EOP is never stuffed.
- R7: NRZI encoding keeps the line state for a one and toggles it for a zero. J is `usb_dp`=1, `usb_dm`=0 and K is the reverse.
- R8: The EOP is two bit times of SE0 (both lines 0) followed by one bit time of J. After it `usb_oe` drops, and the released lines rest at J.
- R9: If `ep_stall` is high when the token is accepted, the block sends sync, PID 1110 (byte 0x1E) and the EOP, and issues no FIFO reads.
- R10: The byte count is captured with the token. A count above MAX_PKT is treated as MAX_PKT.
- R11: `usb_dp`, `usb_dm` and `usb_oe` change only at bit boundaries, CLKS_PER_BIT clock cycles apart.
- R12: During and after reset `usb_oe` and `fifo_rd` are 0, and the lines rest at J.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_tok | input | 1 | One-cycle pulse: IN token for this endpoint |
| pid_odd | input | 1 | 0 selects DATA0, 1 selects DATA1 |
| ep_stall | input | 1 | Endpoint stalled: answer with STALL |
| byte_cnt | input | CNT_W | Payload byte count, captured with the token |
| fifo_data | input | 8 | Head byte of the show-ahead endpoint FIFO |
| fifo_rd | output | 1 | Pop strobe for the endpoint FIFO |
| usb_dp | output | 1 | D+ line level |
| usb_dm | output | 1 | D- line level |
| usb_oe | output | 1 | Line driver enable |

## Verification
The bench builds the block with CLKS_PER_BIT = 4, MAX_PKT = 8 and CNT_W = 4. With this configuration every payload length from zero to the limit can be swept for both data PIDs, and byte counts up to 15 exercise the clamp. The bench also sends all-ones payloads to force long stuffing runs, a STALL response and a token repeated mid-packet. For each packet it builds the expected line symbols arithmetically (raw bits, stuffing, NRZI, EOP) and compares every bit time, including the stability of the lines inside each bit time and the count of FIFO pops.

// File: rtl/usb_tx_pkg.sv
// Package: shared encodings for the USB IN packet transmitter.
// Holds the frame state and line mode types, the PID codes and the
// helper that builds a PID byte with its check nibble.
package usb_tx_pkg;

    typedef enum logic [2:0] {
        FS_IDLE, FS_SYNC, FS_PID, FS_DATA, FS_CRC, FS_SE0, FS_JST, FS_REL
    } frame_st_e;

    typedef enum logic [1:0] {
        LM_IDLE, LM_BIT, LM_SE0, LM_J
    } line_mode_e;

    localparam logic [3:0] PID_DATA0  = 4'b0011;
    localparam logic [3:0] PID_DATA1  = 4'b1011;
    localparam logic [3:0] PID_STALL  = 4'b1110;
    localparam logic [7:0] SYNC_BYTE  = 8'h80;
    localparam logic [15:0] CRC_POLY  = 16'hA001;
    localparam logic [15:0] CRC_SEED  = 16'hFFFF;
    localparam int unsigned STUFF_RUN = 6;

    // Build the on-wire PID byte: code low, complement high.
    function automatic logic [7:0] pid_byte(input logic [3:0] code);
        return {~code, code};
    endfunction

endpackage

// File: rtl/usb_tx_bitclk.sv
// Bit-time strobe generator.
// Produces one tick every DIV clocks while run is high and holds the
// phase at zero while idle, so the first tick of a packet always comes
// DIV clocks after run rises. Assumes DIV >= 1.
module usb_tx_bitclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(DIV - 1));

    // Count clocks within a bit time; restart on tick or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/usb_tx_crc16.sv
// Serial CRC16 in reflected form, one data bit per enabled cycle.
// crc_d is the value after folding din in; crc_q is the stored value.
// clr returns the register to the all-ones seed.
module usb_tx_crc16
    import usb_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic        din,
    output logic [15:0] crc_q,
    output logic [15:0] crc_d
);
    // Next remainder for one incoming bit.
    always_comb begin
        crc_d = (crc_q >> 1) ^ (((crc_q[0] ^ din) == 1'b1) ? CRC_POLY : 16'h0000);
    end

    // Hold the running remainder.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= crc_d;
        end
    end
endmodule

// File: rtl/usb_tx_framer.sv
// Packet framer: sequences sync, PID, payload, CRC and EOP.
// Presents one raw bit (bit_out) and a line mode to the line stage and
// advances only when the line stage takes the bit, so inserted stuff
// bits stall the framer. Assumes a show-ahead FIFO whose head byte is
// valid whenever bytes remain, and CNT_W wide enough for MAX_PKT.
module usb_tx_framer
    import usb_tx_pkg::*;
#(
    parameter int MAX_PKT = 64,
    parameter int CNT_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             take,
    input  logic             in_tok,
    input  logic             pid_odd,
    input  logic             ep_stall,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       fifo_data,
    output logic             fifo_rd,
    output line_mode_e       mode,
    output logic             bit_out,
    output logic             busy,
    output logic             stall_q
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_PKT);

    frame_st_e        st;
    logic [15:0]      sh;
    logic [3:0]       bc;
    logic [CNT_W-1:0] rem;
    logic [7:0]       pid_r;
    logic [CNT_W-1:0] cnt_cl;
    logic             last8;
    logic             crc_clr;
    logic             crc_en;
    logic [15:0]      crc_q;
    logic [15:0]      crc_d;

    assign busy    = (st != FS_IDLE);
    assign bit_out = sh[0];
    assign last8   = (bc == 4'd7);
    assign cnt_cl  = (byte_cnt > MAX_CNT) ? MAX_CNT : byte_cnt;
    assign crc_clr = (st == FS_IDLE) && in_tok;
    assign crc_en  = take && (st == FS_DATA);

    // Pop the FIFO when the last bit of the PID or of a payload byte is taken.
    assign fifo_rd = take && last8 && (rem != '0)
                   && (((st == FS_PID) && !stall_q) || (st == FS_DATA));

    // Map the frame state to what the line stage should emit.
    always_comb begin
        case (st)
            FS_SYNC, FS_PID, FS_DATA, FS_CRC: mode = LM_BIT;
            FS_SE0:                           mode = LM_SE0;
            FS_JST:                           mode = LM_J;
            default:                          mode = LM_IDLE;
        endcase
    end

    usb_tx_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (sh[0]),
        .crc_q (crc_q),
        .crc_d (crc_d)
    );

    // Frame sequencer: load fields and step through them bit by bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FS_IDLE;
            sh      <= '0;
            bc      <= '0;
            rem     <= '0;
            pid_r   <= '0;
            stall_q <= 1'b0;
        end else begin
            case (st)
                FS_IDLE: begin
                    if (in_tok) begin
                        st      <= FS_SYNC;
                        sh      <= {8'h00, SYNC_BYTE};
                        bc      <= '0;
                        rem     <= cnt_cl;
                        stall_q <= ep_stall;
                        pid_r   <= ep_stall ? pid_byte(PID_STALL)
                                            : pid_byte(pid_odd ? PID_DATA1 : PID_DATA0);
                    end
                end
                FS_SYNC: begin
                    if (take) begin
                        if (last8) begin
                            st <= FS_PID;
                            sh <= {8'h00, pid_r};
                            bc <= '0;
                        end else begin
                            sh <= sh >> 1;
                            bc <= bc + 1'b1;
                        end
                    end
                end
                FS_PID: begin
                    if (take) begin
                        bc <= last8 ? 4'd0 : bc + 1'b1;
                        if (!last8) begin
                            sh <= sh >> 1;
                        end else if (stall_q) begin
                            st <= FS_SE0;
                        end else if (rem == '0) begin
                            st <= FS_CRC;
                            sh <= ~crc_q;
                        end else begin
                            st  <= FS_DATA;
                            sh  <= {8'h00, fifo_data};
                            rem <= rem - 1'b1;
                        end
                    end
                end
                FS_DATA: begin
                    if (take) begin
                        bc <= last8 ? 4'd0 : bc + 1'b1;
                        if (!last8) begin
                            sh <= sh >> 1;
                        end else if (rem == '0) begin
                            st <= FS_CRC;
                            sh <= ~crc_d;
                        end else begin
                            sh  <= {8'h00, fifo_data};
                            rem <= rem - 1'b1;
                        end
                    end
                end
                FS_CRC: begin
                    if (take) begin
                        sh <= sh >> 1;
                        if (bc == 4'd15) begin
                            st <= FS_SE0;
                            bc <= '0;
                        end else begin
                            bc <= bc + 1'b1;
                        end
                    end
                end
                FS_SE0: begin
                    if (take) begin
                        if (bc == 4'd1) begin
                            st <= FS_JST;
                            bc <= '0;
                        end else begin
                            bc <= bc + 1'b1;
                        end
                    end
                end
                FS_JST: begin
                    if (take) begin
                        st <= FS_REL;
                    end
                end
                default: begin
                    if (tick) begin
                        st <= FS_IDLE;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/usb_tx_line.sv
// Line stage: bit stuffer, NRZI encoder and output drivers.
// On each bit tick it registers the symbol for the next bit time.
// After STUFF_RUN ones it emits a zero without taking a framer bit.
// SE0 and J modes bypass NRZI and reset the run count.
module usb_tx_line
    import usb_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  line_mode_e mode,
    input  logic       bit_in,
    output logic       take,
    output logic       dp,
    output logic       dm,
    output logic       oe
);
    logic       lvl;
    logic       se0;
    logic [2:0] ones;
    logic       stuff_now;

    assign stuff_now = (ones == 3'(STUFF_RUN));
    assign take      = tick && (mode != LM_IDLE) && !stuff_now;
    assign dp        = se0 ? 1'b0 : lvl;
    assign dm        = se0 ? 1'b0 : ~lvl;

    // Register the line symbol for the coming bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl  <= 1'b1;
            se0  <= 1'b0;
            oe   <= 1'b0;
            ones <= '0;
        end else if (tick) begin
            if (mode == LM_IDLE) begin
                lvl  <= 1'b1;
                se0  <= 1'b0;
                oe   <= 1'b0;
                ones <= '0;
            end else if (stuff_now) begin
                lvl  <= ~lvl;
                se0  <= 1'b0;
                oe   <= 1'b1;
                ones <= '0;
            end else begin
                oe <= 1'b1;
                case (mode)
                    LM_BIT: begin
                        se0 <= 1'b0;
                        if (bit_in) begin
                            ones <= ones + 1'b1;
                        end else begin
                            lvl  <= ~lvl;
                            ones <= '0;
                        end
                    end
                    LM_SE0: begin
                        se0  <= 1'b1;
                        ones <= '0;
                    end
                    default: begin
                        se0  <= 1'b0;
                        lvl  <= 1'b1;
                        ones <= '0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/usb_in_xmit.sv
// Top: USB IN data packet transmitter for one endpoint.
// Ties the bit-time strobe, the framer and the line stage together.
// Assumes in_tok is a one-cycle pulse and the FIFO is show-ahead.
module usb_in_xmit
    import usb_tx_pkg::*;
#(
    parameter int CLKS_PER_BIT = 4,
    parameter int MAX_PKT      = 64,
    parameter int CNT_W        = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_tok,
    input  logic             pid_odd,
    input  logic             ep_stall,
    input  logic [CNT_W-1:0] byte_cnt,
    input  logic [7:0]       fifo_data,
    output logic             fifo_rd,
    output logic             usb_dp,
    output logic             usb_dm,
    output logic             usb_oe
);
    logic       bit_tick;
    logic       busy;
    logic       take;
    logic       raw_bit;
    logic       stall_lat;
    line_mode_e mode;

    usb_tx_bitclk #(.DIV(CLKS_PER_BIT)) u_bitclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (bit_tick)
    );

    usb_tx_framer #(.MAX_PKT(MAX_PKT), .CNT_W(CNT_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .take      (take),
        .in_tok    (in_tok),
        .pid_odd   (pid_odd),
        .ep_stall  (ep_stall),
        .byte_cnt  (byte_cnt),
        .fifo_data (fifo_data),
        .fifo_rd   (fifo_rd),
        .mode      (mode),
        .bit_out   (raw_bit),
        .busy      (busy),
        .stall_q   (stall_lat)
    );

    usb_tx_line u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (bit_tick),
        .mode   (mode),
        .bit_in (raw_bit),
        .take   (take),
        .dp     (usb_dp),
        .dm     (usb_dm),
        .oe     (usb_oe)
    );
endmodule

// File: rtl/usb_in_xmit_chk.sv
// Checker for usb_in_xmit: line timing, framing edges and FIFO use.
// Bound into every instance of the top module below.
module usb_in_xmit_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic dp,
    input logic dm,
    input logic oe,
    input logic fifo_rd,
    input logic stall_lat
);
    // Lines move only on bit-time strobes.
    assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({dp, dm, oe}));

    // The first driven bit time is the K that opens the sync field.
    assert_sync_opens_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> (!dp && dm));

    // Drivers are released only after a J bit time.
    assert_release_after_j_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> $past(dp && !dm));

    // SE0 never appears on released lines.
    assert_se0_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp && !dm) |-> oe);

    // FIFO reads happen only during a data packet.
    assert_pop_in_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (oe && !stall_lat));

    // Both lines high is never produced.
    assert_no_se1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(dp && dm));
endmodule

bind usb_in_xmit usb_in_xmit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (bit_tick),
    .dp        (usb_dp),
    .dm        (usb_dm),
    .oe        (usb_oe),
    .fifo_rd   (fifo_rd),
    .stall_lat (stall_lat)
);

// File: tb/sim_usb_in_xmit.sv
// Bench for usb_in_xmit: sweeps payload lengths and PIDs in a small
// configuration and compares each bit time against symbols built
// arithmetically from the requirements.
module sim_usb_in_xmit;
    localparam int DIV   = 4;
    localparam int MAXP  = 8;
    localparam int CW    = 4;
    localparam int S_SE0 = 0;
    localparam int S_J   = 1;
    localparam int S_K   = 2;
    localparam int S_OFF = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_tok = 1'b0;
    logic          pid_odd = 1'b0;
    logic          ep_stall = 1'b0;
    logic [CW-1:0] byte_cnt = '0;
    logic [7:0]    fifo_data;
    logic          fifo_rd;
    logic          usb_dp;
    logic          usb_dm;
    logic          usb_oe;

    logic [7:0] mem [16];
    int ptr = 0;
    int pops = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int exp_sym [300];
    int got_sym [300];
    int exp_n;
    int raw [200];

    always #4 clk = ~clk;

    assign fifo_data = mem[ptr[3:0]];

    // FIFO model: show-ahead, pops counted.
    always @(posedge clk) begin
        if (fifo_rd) begin
            ptr  <= ptr + 1;
            pops <= pops + 1;
        end
    end

    usb_in_xmit #(.CLKS_PER_BIT(DIV), .MAX_PKT(MAXP), .CNT_W(CW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_tok    (in_tok),
        .pid_odd   (pid_odd),
        .ep_stall  (ep_stall),
        .byte_cnt  (byte_cnt),
        .fifo_data (fifo_data),
        .fifo_rd   (fifo_rd),
        .usb_dp    (usb_dp),
        .usb_dm    (usb_dm),
        .usb_oe    (usb_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int line_sym();
        if (!usb_oe) return S_OFF;
        if (!usb_dp && !usb_dm) return S_SE0;
        if (usb_dp && !usb_dm) return S_J;
        if (!usb_dp && usb_dm) return S_K;
        return 9;
    endfunction

    // Expected symbols: raw bits, stuffing (R6), NRZI (R7), EOP (R8).
    task automatic build_exp(input bit stl, input bit odd, input int n);
        int nr = 0;
        int ones = 0;
        int lvl = 1;
        logic [15:0] crc = 16'hFFFF;
        logic [7:0] b;
        for (int i = 0; i < 8; i++) raw[nr++] = (8'h80 >> i) & 1;
        b = stl ? 8'h1E : (odd ? 8'h4B : 8'hC3);
        for (int i = 0; i < 8; i++) raw[nr++] = b[i];
        if (!stl) begin
            for (int k = 0; k < n; k++) begin
                for (int i = 0; i < 8; i++) begin
                    raw[nr++] = mem[k][i];
                    if (crc[0] != mem[k][i]) crc = (crc >> 1) ^ 16'hA001;
                    else crc = crc >> 1;
                end
            end
            crc = ~crc;
            for (int i = 0; i < 16; i++) raw[nr++] = crc[i];
        end
        exp_n = 0;
        for (int i = 0; i < nr; i++) begin
            if (raw[i] == 0) begin lvl = 1 - lvl; ones = 0; end
            else ones++;
            exp_sym[exp_n++] = lvl ? S_J : S_K;
            if (ones == 6) begin
                lvl = 1 - lvl;
                ones = 0;
                exp_sym[exp_n++] = lvl ? S_J : S_K;
            end
        end
        exp_sym[exp_n++] = S_SE0;
        exp_sym[exp_n++] = S_SE0;
        exp_sym[exp_n++] = S_J;
    endtask

    task automatic run_pkt(input bit stl, input bit odd, input int cnt, input bit extra);
        int n = stl ? 0 : ((cnt > MAXP) ? MAXP : cnt);
        int idx = 1;
        int ns = 0;
        int unstable = 0;
        int base;
        int s;
        int syncp [8] = '{S_K, S_J, S_K, S_J, S_K, S_J, S_K, S_K};
        bit same;
        build_exp(stl, odd, n);
        @(negedge clk);
        ptr = 0;
        base = pops;
        in_tok = 1'b1; pid_odd = odd; ep_stall = stl; byte_cnt = CW'(cnt);
        @(negedge clk);
        in_tok = 1'b0;
        while (!usb_oe && idx < 100) begin
            @(negedge clk);
            idx++;
        end
        check(idx == DIV + 1, "R1 start latency", idx, DIV + 1);
        while (ns < 299) begin
            s = line_sym();
            got_sym[ns++] = s;
            for (int j = 1; j < DIV; j++) begin
                in_tok = (extra && ns == 10 && j == 1);
                @(negedge clk);
                if (line_sym() != s) unstable++;
            end
            in_tok = 1'b0;
            @(negedge clk);
            if (!usb_oe) break;
        end
        check(unstable == 0, "R11 stable within bit time", unstable, 0);
        check(usb_dp && !usb_dm, "R8 released lines rest at J", {usb_dp, usb_dm}, 2);
        check(ns == exp_n, "R6 stuffed bit-time count", ns, exp_n);
        same = 1;
        for (int i = 0; i < 8; i++) if (got_sym[i] != syncp[i]) same = 0;
        check(same, "R2 sync pattern", got_sym[7], S_K);
        check(got_sym[ns-3] == S_SE0 && got_sym[ns-2] == S_SE0 && got_sym[ns-1] == S_J,
              "R8 EOP", got_sym[ns-3], S_SE0);
        same = (ns == exp_n);
        for (int i = 0; i < ns && i < exp_n; i++) if (got_sym[i] != exp_sym[i]) same = 0;
        check(same, stl ? "R9 STALL handshake bits" : "R3 R4 R5 R7 packet bits", ns, exp_n);
        check(pops - base == n, stl ? "R9 no FIFO reads" : "R4 R10 FIFO pop count", pops - base, n);
        for (int j = 0; j < 3 * DIV; j++) @(negedge clk);
        check(!usb_oe, "R1 no packet from ignored token", usb_oe, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        check(!usb_oe && !fifo_rd && usb_dp && !usb_dm, "R12 state in reset",
              {usb_oe, fifo_rd, usb_dp, usb_dm}, 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!usb_oe && !fifo_rd && usb_dp && !usb_dm, "R12 idle after reset",
              {usb_oe, fifo_rd, usb_dp, usb_dm}, 2);
        // Sweep every length for both data PIDs (R3, R4, R5).
        for (int odd = 0; odd < 2; odd++) begin
            for (int n = 0; n <= MAXP; n++) begin
                for (int i = 0; i < 16; i++) mem[i] = 8'((n * 37 + i * 91 + odd * 85) & 255);
                run_pkt(1'b0, odd[0], n, 1'b0);
            end
        end
        // Long one runs force stuffing in payload and CRC (R6).
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        run_pkt(1'b0, 1'b0, MAXP, 1'b0);
        run_pkt(1'b0, 1'b1, 3, 1'b0);
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        run_pkt(1'b0, 1'b1, MAXP, 1'b0);
        // Counts above the limit are clamped (R10).
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + 3);
        run_pkt(1'b0, 1'b0, 12, 1'b0);
        run_pkt(1'b0, 1'b1, 15, 1'b0);
        // Stalled endpoint answers with STALL (R9).
        run_pkt(1'b1, 1'b0, 5, 1'b0);
        run_pkt(1'b1, 1'b1, 0, 1'b0);
        // Token repeated during a packet is ignored (R1).
        run_pkt(1'b0, 1'b0, 4, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule